// File: doc/BRIEF.md
# MDIO Management Bus Master

This block runs a single register access to an Ethernet PHY over the two-wire management bus. The host raises a one-cycle start request. The request carries a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then owns the bus until the frame is complete. When it finishes, it pulses a done flag. It returns the read data and an error flag, and both stay valid until the next request is accepted.

The management clock comes from the system clock. Two parameters count its phases in system clock cycles: one sets each half period of a driven bit, and the other sets the longer high phase used when the PHY drives the line. The data line is split into an output value, an output enable and an input, so a pad or the surrounding logic builds the tri-state buffer. The input passes through a two-flop synchroniser before it is sampled. A read whose turnaround bit is not pulled low counts as failed. In that case the block keeps clocking with the line released so the PHY can drain its output, then reports all-ones data and sets the error flag.

Top module: `mdio_master`

## Requirements
- R1: Every frame begins with 32 management clock cycles in which the master drives the data line to 1.
- R2: After the preamble the master drives, MSB first and in this order: start bits 0,1; opcode 1,0 for a read or 0,1 for a write; the 5-bit PHY address; the 5-bit register address.
- R3: For a write, the master next drives turnaround bits 1,0 and then the 16 write data bits MSB first.
- R4: For a read, the output enable is low from the bit after the register address onward. The master samples the turnaround bit, and when it is 0 it shifts in 16 data bits MSB first. It then returns them on rdata_o with err_o low.
- R5: If the sampled read turnaround bit is 1, the master clocks 32 more cycles with the line released and ignores their values. It then completes with rdata_o = 16'hFFFF and err_o high, with no further cycle. The frame is therefore 79 clock cycles long.
- R6: After the last data bit of a write or a good read, the master gives exactly one more clock cycle with the line released before done. A write frame is therefore 65 cycles long and a good read 64.
- R7: The data line and its enable are stable whenever MDC is high. Each low phase lasts at least HALF_CYC system cycles. The high phase lasts exactly HALF_CYC cycles on driven bits and RD_HIGH_CYC cycles on received bits. Received bits are sampled as MDC falls.
- R8: A start request while busy_o is high is ignored: the frame in flight is unchanged and no second frame follows it.
- R9: After reset MDC, the output enable, busy_o, done_o, rdata_o and err_o are all 0. done_o is a one-cycle pulse in the cycle busy_o falls. rdata_o and err_o hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a transaction (taken only when idle) |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result |
| err_o | output | 1 | Read turnaround failure |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
Two events can fall in the same system cycle: completion of one frame, with done pulsing and busy falling, and acceptance of the next start request. The bench provokes this by raising start in the very cycle it sees done after a failed read. It then checks three things: the error result was visible in the done cycle, both results cleared as the new request was taken, and the following write frame has the correct bits. Start requests raised while a frame is in flight are judged by comparing the captured frame with the original request, and by confirming that busy stays low afterwards.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    F_IDLE, F_PRE, F_HDR, F_RTA, F_RDATA, F_FLUSH, F_TAIL
  } frm_st_e;

  typedef enum logic [1:0] {
    E_IDLE, E_LOW, E_HIGH
  } eng_st_e;
endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  // reset to 1: released line idles high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer
  import mdio_pkg::*;
#(
  parameter int HALF_CYC    = 63,
  parameter int RD_HIGH_CYC = 88
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic rx_i,
  input  logic sample_i,
  output logic idle_o,
  output logic mdc_o,
  output logic done_o,
  output logic bit_o
);
  localparam int MAX_C = (HALF_CYC > RD_HIGH_CYC) ? HALF_CYC : RD_HIGH_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam int MON_W = CNT_W + 1;

  eng_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= E_IDLE;
      cnt_q  <= '0;
      rx_q   <= 1'b0;
      mdc_o  <= 1'b0;
      done_o <= 1'b0;
      bit_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        E_IDLE: if (go_i) begin
          st_q  <= E_LOW;
          cnt_q <= CNT_W'(HALF_CYC - 1);
          rx_q  <= rx_i;
        end
        E_LOW: if (cnt_q == '0) begin
          st_q  <= E_HIGH;
          mdc_o <= 1'b1;
          cnt_q <= rx_q ? CNT_W'(RD_HIGH_CYC - 1) : CNT_W'(HALF_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        E_HIGH: if (cnt_q == '0) begin
          st_q   <= E_IDLE;
          mdc_o  <= 1'b0;
          done_o <= 1'b1;
          bit_o  <= sample_i;  // sample as MDC falls
        end else cnt_q <= cnt_q - 1'b1;
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign idle_o = (st_q == E_IDLE);

  // phase-length monitors for assertions
  logic [MON_W-1:0] lo_len_q, hi_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_len_q <= '0;
      hi_len_q <= '0;
    end else begin
      if (mdc_o) lo_len_q <= '0;
      else if (lo_len_q != '1) lo_len_q <= lo_len_q + 1'b1;
      if (!mdc_o) hi_len_q <= '0;
      else if (hi_len_q != '1) hi_len_q <= hi_len_q + 1'b1;
    end
  end

  p_low_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> int'(lo_len_q) >= HALF_CYC);

  p_high_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdc_o) |-> int'(hi_len_q) == (rx_q ? RD_HIGH_CYC : HALF_CYC));

  p_done_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(mdc_o));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYC    = 63,
  parameter int RD_HIGH_CYC = 88,
  parameter int PRE_LEN     = 32,
  parameter int FLUSH_LEN   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int RD_HDR_LEN = 4 + 2 * ADDR_W;
  localparam int FRAME_W    = RD_HDR_LEN + 2 + DATA_W;
  localparam int MAX_A      = (PRE_LEN > FRAME_W) ? PRE_LEN : FRAME_W;
  localparam int MAX_LEN    = (MAX_A > FLUSH_LEN) ? MAX_A : FLUSH_LEN;
  localparam int CNT_W      = $clog2(MAX_LEN + 1);

  frm_st_e            st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] tx_sr_q;
  logic [DATA_W-1:0]  rx_sr_q;
  logic               rd_q;
  logic               mdi_s;
  logic               eng_idle, bit_done, bit_s;
  logic               issue, issue_rx, issue_val;

  mdio_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mdio_i),
    .q_o   (mdi_s)
  );

  mdio_bit_timer #(.HALF_CYC(HALF_CYC), .RD_HIGH_CYC(RD_HIGH_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (issue),
    .rx_i    (issue_rx),
    .sample_i(mdi_s),
    .idle_o  (eng_idle),
    .mdc_o   (mdc_o),
    .done_o  (bit_done),
    .bit_o   (bit_s)
  );

  always_comb begin
    issue     = (st_q != F_IDLE) && eng_idle && !bit_done;
    issue_rx  = (st_q == F_RTA) || (st_q == F_RDATA) ||
                (st_q == F_FLUSH) || (st_q == F_TAIL);
    issue_val = (st_q == F_HDR) ? tx_sr_q[FRAME_W-1] : 1'b1;
  end

  // line drivers change only when a new bit starts, MDC low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdio_o    <= 1'b1;
      mdio_oe_o <= 1'b0;
    end else if (issue) begin
      mdio_o    <= issue_val;
      mdio_oe_o <= !issue_rx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= F_IDLE;
      cnt_q   <= '0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      rd_q    <= 1'b0;
      done_o  <= 1'b0;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (st_q == F_IDLE) begin
        if (start_i) begin
          st_q    <= F_PRE;
          cnt_q   <= CNT_W'(PRE_LEN - 1);
          rd_q    <= rd_i;
          tx_sr_q <= {2'b01, rd_i ? 2'b10 : 2'b01, phy_addr_i, reg_addr_i,
                      2'b10, wdata_i};
          rx_sr_q <= '0;
          rdata_o <= '0;
          err_o   <= 1'b0;
        end
      end else if (bit_done) begin
        case (st_q)
          F_PRE: if (cnt_q == '0) begin
            st_q  <= F_HDR;
            cnt_q <= rd_q ? CNT_W'(RD_HDR_LEN - 1) : CNT_W'(FRAME_W - 1);
          end else cnt_q <= cnt_q - 1'b1;
          F_HDR: begin
            tx_sr_q <= {tx_sr_q[FRAME_W-2:0], 1'b0};
            if (cnt_q == '0) st_q <= rd_q ? F_RTA : F_TAIL;
            else             cnt_q <= cnt_q - 1'b1;
          end
          F_RTA: if (bit_s) begin
            st_q  <= F_FLUSH;
            cnt_q <= CNT_W'(FLUSH_LEN - 1);
          end else begin
            st_q  <= F_RDATA;
            cnt_q <= CNT_W'(DATA_W - 1);
          end
          F_RDATA: begin
            rx_sr_q <= {rx_sr_q[DATA_W-2:0], bit_s};
            if (cnt_q == '0) st_q <= F_TAIL;
            else             cnt_q <= cnt_q - 1'b1;
          end
          F_FLUSH: if (cnt_q == '0) begin
            st_q    <= F_IDLE;
            done_o  <= 1'b1;
            rdata_o <= '1;
            err_o   <= 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
          F_TAIL: begin
            st_q   <= F_IDLE;
            done_o <= 1'b1;
            if (rd_q) rdata_o <= rx_sr_q;
          end
          default: st_q <= F_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (st_q != F_IDLE);

  p_line_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  p_preamble_ones_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && st_q == F_PRE) |-> (mdio_oe_o && mdio_o));

  p_rx_released_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && (st_q == F_RTA || st_q == F_RDATA || st_q == F_FLUSH ||
               st_q == F_TAIL)) |-> !mdio_oe_o);

  p_err_all_ones_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '1));

  p_req_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(rd_q));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_busy_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $fell(busy_o)));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mdc_o && !mdio_oe_o));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int HALF = 4;
  localparam int RDH  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start = 1'b0, rd = 1'b0;
  logic [4:0]  phy = '0, rg = '0;
  logic [15:0] wdata = '0;
  logic        busy, done, err, mdc, mdo, mdoe, mdi;
  logic [15:0] rdata;

  mdio_master #(.HALF_CYC(HALF), .RD_HIGH_CYC(RDH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_i(rd),
    .phy_addr_i(phy), .reg_addr_i(rg), .wdata_i(wdata),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .err_o(err),
    .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(mdoe), .mdio_i(mdi)
  );

  // PHY model
  logic        m_rd = 1'b0, m_ta_ok = 1'b1;
  logic [15:0] m_data = '0;
  int          nbits = 0;
  logic        phy_en, phy_val;
  always_comb begin
    phy_en = 1'b0;
    phy_val = 1'b1;
    if (m_rd && nbits == 46 && m_ta_ok) begin
      phy_en = 1'b1; phy_val = 1'b0;
    end else if (m_rd && m_ta_ok && nbits >= 47 && nbits <= 62) begin
      phy_en = 1'b1; phy_val = m_data[62 - nbits];
    end
  end
  assign mdi = mdoe ? mdo : (phy_en ? phy_val : 1'b1);

  // bus monitor
  logic [95:0] cap_oe, cap_val;
  logic        mdc_prev = 1'b0, busy_prev = 1'b0;
  int          hi_len = 0, lo_len = 0, timing_bad = 0;
  always @(negedge clk) begin
    if (busy && !busy_prev) begin
      nbits = 0; timing_bad = 0; lo_len = HALF;
    end
    if (mdc && !mdc_prev) begin
      if (lo_len < HALF) timing_bad++;
      if (nbits < 96) begin
        cap_oe[nbits]  = mdoe;
        cap_val[nbits] = mdi;
      end
      hi_len = 1;
    end else if (mdc) begin
      hi_len++;
      if (nbits < 96 && (mdoe !== cap_oe[nbits] || mdi !== cap_val[nbits]))
        timing_bad++;
    end else if (!mdc && mdc_prev) begin
      if (nbits < 96 && hi_len != (cap_oe[nbits] ? HALF : RDH)) timing_bad++;
      nbits++;
      lo_len = 1;
    end else lo_len++;
    mdc_prev  = mdc;
    busy_prev = busy;
  end

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string tag, input longint act,
                     input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_hdr(input logic r, input logic [4:0] p,
                                          input logic [4:0] a,
                                          input logic [15:0] d);
    return {2'b01, r ? 2'b10 : 2'b01, p, a, 2'b10, d};
  endfunction

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk); n++;
    end
    if (!done) chk(1'b0, "watchdog R9", n, 5000);
  endtask

  task automatic check_frame(input logic r, input logic ta_ok,
                             input logic [31:0] hdr);
    int nexp = r ? (ta_ok ? 64 : 79) : 65;
    int hl = r ? 14 : 32;
    int ones = 0, hbad = 0, dbad = 0, rel = 0;
    chk(nbits == nexp, r && !ta_ok ? "R5 length" : "R6 length", nbits, nexp);
    for (int k = 0; k < 32; k++) if (cap_oe[k] && cap_val[k]) ones++;
    chk(ones == 32, "R1 preamble", ones, 32);
    for (int k = 0; k < hl; k++)
      if (!cap_oe[32+k] || cap_val[32+k] != hdr[31-k]) begin
        if (k < 14) hbad++; else dbad++;
      end
    chk(hbad == 0, "R2 header", hbad, 0);
    if (!r) chk(dbad == 0, "R3 write ta/data", dbad, 0);
    for (int k = 32 + hl; k < nexp && k < 96; k++) if (cap_oe[k]) rel++;
    chk(rel == 0, r ? "R4 released" : "R6 tail released", rel, 0);
    chk(timing_bad == 0, "R7 timing", timing_bad, 0);
  endtask

  task automatic run(input logic r, input logic [4:0] p, input logic [4:0] a,
                     input logic [15:0] d, input logic ta_ok,
                     input logic [15:0] pd, input bit poke);
    logic [31:0] hdr = exp_hdr(r, p, a, d);
    @(negedge clk);
    m_rd = r; m_ta_ok = ta_ok; m_data = pd;
    start = 1'b1; rd = r; phy = p; rg = a; wdata = d;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy", busy, 1);
    if (poke) begin
      // R8: new requests while busy
      repeat (200) @(negedge clk);
      start = 1'b1; rd = ~r; phy = ~p; rg = ~a; wdata = ~d;
      @(negedge clk);
      start = 1'b0;
      repeat (150) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done();
    chk(busy == 1'b0, "R9 busy falls with done", busy, 0);
    if (r && ta_ok) begin
      chk(rdata == pd, "R4 read data", rdata, pd);
      chk(err == 1'b0, "R4 err low", err, 0);
    end else if (r) begin
      chk(rdata == 16'hFFFF, "R5 all ones", rdata, 16'hFFFF);
      chk(err == 1'b1, "R5 err", err, 1);
    end else chk(err == 1'b0, "R3 err low", err, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done pulse", done, 0);
    check_frame(r, ta_ok, hdr);
    if (poke) begin
      repeat (40) @(negedge clk);
      chk(busy == 1'b0, "R8 no second frame", busy, 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "watchdog R9", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(mdc == 0 && mdoe == 0 && busy == 0 && done == 0,
        "R9 reset outputs", {mdc, mdoe, busy, done}, 0);
    chk(rdata == 0 && err == 0, "R9 reset result", {err, rdata}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners
    run(1'b0, 5'h1F, 5'h00, 16'hA5C3, 1'b1, 16'h0, 1'b0);
    run(1'b1, 5'h00, 5'h1F, 16'h0, 1'b1, 16'h8001, 1'b0);
    run(1'b1, 5'h15, 5'h0A, 16'h0, 1'b1, 16'hFFFF, 1'b0);
    run(1'b1, 5'h03, 5'h11, 16'h0, 1'b0, 16'h1234, 1'b0);
    run(1'b0, 5'h0C, 5'h13, 16'h0000, 1'b1, 16'h0, 1'b1);
    run(1'b1, 5'h07, 5'h02, 16'h0, 1'b1, 16'h5A5A, 1'b1);

    // R9 hold after a good read
    held = rdata;
    repeat (50) @(negedge clk);
    chk(rdata == held && err == 1'b0, "R9 hold", rdata, held);

    // back-to-back: failed read, new start in the done cycle
    @(negedge clk);
    m_rd = 1'b1; m_ta_ok = 1'b0;
    start = 1'b1; rd = 1'b1; phy = 5'h09; rg = 5'h04;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(err == 1'b1 && rdata == 16'hFFFF, "R5 before restart", {err, rdata}, 17'h1FFFF);
    m_rd = 1'b0; m_ta_ok = 1'b1;
    start = 1'b1; rd = 1'b0; phy = 5'h11; rg = 5'h1E; wdata = 16'h3C96;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0 && busy == 1'b1, "R9 restart accepted", {done, busy}, 1);
    chk(err == 1'b0 && rdata == 16'h0, "R9 cleared on start", {err, rdata}, 0);
    wait_done();
    chk(err == 1'b0, "R3 err low", err, 0);
    @(negedge clk);
    check_frame(1'b0, 1'b1, exp_hdr(1'b0, 5'h11, 5'h1E, 16'h3C96));

    // constrained random
    for (int i = 0; i < 24; i++) begin
      logic r = 1'($urandom);
      logic ok = ($urandom % 4) != 0;
      run(r, 5'($urandom), 5'($urandom), 16'($urandom), ok, 16'($urandom), 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule